// File: doc/BRIEF.md
# Period-Based Frequency Meter

This block reports the frequency of a square wave that arrives from outside the chip, with no phase relation to the system clock. The wave is first resampled through a short chain of flip-flops. Falling edges are then found by comparing two registered copies of the wave. The raw pin never reaches the edge logic.

A small controller counts system clocks from one falling edge to the next. It hands that period to a serial restoring divider, which computes the clock rate divided by the period. The quotient is the input frequency in hertz. It appears on `freq_o` along with a one-cycle `valid_o` strobe. If a period runs past a configurable limit, the controller gives up, pulses `ovf_o` and waits for a fresh edge.

With the defaults (50 MHz clock, 27-bit counter, a one-second limit) a 50 kHz input gives a count of 1000 and a reading of 50000.

Top module: `freq_meter`

## Requirements
- R1: The input passes through `SYNC_STAGES` flip-flops (default 2, all cleared by reset) before any edge logic. A falling edge is flagged when the older of the last two stages holds 1 and the newer holds 0. A fall on the pin therefore reaches the detector `SYNC_STAGES` clocks later.
- R2: From idle, the first detected falling edge starts a measurement. The next detected falling edge ends it. The period is the number of clocks between the two edges, and the result is `freq_o` = floor(`CLK_HZ` / period).
- R3: Each result is marked by `valid_o` high for exactly one cycle. `freq_o` keeps that value until the next result.
- R4: The count limit is min(`TIMEOUT_CYC`, 2^`CNT_W`-1). If the count reaches the limit and no edge arrives in that cycle, `ovf_o` pulses for one cycle, no result is given and the block returns to idle. An edge in that same cycle takes priority, and the limit itself is reported as a normal period.
- R5: The divider produces one quotient bit per clock. `busy_o` is high for exactly `CNT_W` cycles per division. `valid_o` rises one cycle after `busy_o` falls. No measurement starts while `busy_o` is high.
- R6: Any state encoding outside the four legal states returns the controller to idle on the next clock, with no `valid_o` and no `ovf_o`.
- R7: `rst_i` is active high and synchronous. It clears the synchronizer, the counter and the state, and drives `freq_o`, `valid_o`, `ovf_o` and `busy_o` to 0. A falling edge on the pin during reset starts no measurement.
- R8: For input periods that are a whole number of clocks, the result is within ±1 of the nominal frequency whatever the sub-clock phase of the input.
- R9: `valid_o` and `ovf_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| sig_i | input | 1 | Asynchronous square wave to measure |
| freq_o | output | CNT_W | Last measured frequency in Hz |
| valid_o | output | 1 | One-cycle strobe marking a new `freq_o` |
| ovf_o | output | 1 | One-cycle strobe: period exceeded the limit |
| busy_o | output | 1 | Divider is running |

## Verification
The limit check and the closing edge can fall in the same clock. This happens when the second falling edge is detected in the very cycle the counter equals the limit. The bench provokes this with a wave whose period is exactly the limit. It then repeats the run with a period one clock longer. It judges the first case by a correct `valid_o` result and no `ovf_o`, and the second by `ovf_o` pulses and the absence of any `valid_o` over several periods.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;

  // Controller states; the remaining 3-bit codes are illegal.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_COUNT  = 3'd1,
    ST_DIVIDE = 3'd2,
    ST_DONE   = 3'd3
  } state_e;

endpackage

// File: rtl/fm_sync_edge.sv
`timescale 1ns/1ps
module fm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sig_i,
  output logic fall_o
);

  // stg_q[0] is the newest sample, stg_q[STAGES-1] the oldest.
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= sig_i;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  // Only registered copies feed the edge compare.
  assign fall_o = stg_q[STAGES-1] & ~stg_q[STAGES-2];

endmodule

// File: rtl/fm_divider.sv
`timescale 1ns/1ps
module fm_divider #(
  parameter int W = 27
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o
);

  localparam int SW = $clog2(W + 1);

  logic [W-1:0]  num_q, den_q, quo_q, rem_q;
  logic [SW-1:0] step_q;
  logic          busy_q, done_q;
  logic [W:0]    step_w;

  // One restoring step: returns {quotient bit, new remainder}.
  function automatic logic [W:0] div_step(input logic [W-1:0] rem,
                                          input logic         bit_in,
                                          input logic [W-1:0] den);
    logic [W:0] sh;
    logic [W:0] dx;
    sh = {rem, bit_in};
    dx = {1'b0, den};
    if (sh >= dx) return {1'b1, W'(sh - dx)};
    else          return {1'b0, W'(sh)};
  endfunction

  assign step_w = div_step(rem_q, num_q[W-1], den_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      num_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          num_q  <= num_i;
          den_q  <= den_i;
          rem_q  <= '0;
          quo_q  <= '0;
          step_q <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        num_q  <= {num_q[W-2:0], 1'b0};
        quo_q  <= {quo_q[W-2:0], step_w[W]};
        rem_q  <= step_w[W-1:0];
        step_q <= step_q + SW'(1);
        if (step_q == SW'(W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;

endmodule

// File: rtl/fm_ctrl.sv
`timescale 1ns/1ps
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int               CNT_W = 27,
  parameter logic [CNT_W-1:0] LIMIT = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             fall_i,
  input  logic             div_busy_i,
  input  logic             div_done_i,
  input  logic [CNT_W-1:0] quo_i,
  output logic             start_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] freq_o,
  output logic             valid_o,
  output logic             ovf_o,
  output state_e           state_o,
  output logic [CNT_W-1:0] cnt_o
);

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q, period_q, freq_q;
  logic             start_q, ovf_q;

  // Saturating increment for the period counter.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      period_q <= '0;
      freq_q   <= '0;
      start_q  <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      ovf_q   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fall_i && !div_busy_i) begin
            cnt_q   <= CNT_W'(1);
            state_q <= ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (fall_i) begin
            period_q <= cnt_q;
            start_q  <= 1'b1;
            state_q  <= ST_DIVIDE;
          end else if (cnt_q >= LIMIT) begin
            ovf_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= sat_inc(cnt_q);
          end
        end
        ST_DIVIDE: begin
          if (div_done_i) begin
            freq_q  <= quo_i;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_o  = start_q;
  assign period_o = period_q;
  assign freq_o   = freq_q;
  assign valid_o  = (state_q == ST_DONE);
  assign ovf_o    = ovf_q;
  assign state_o  = state_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter
  import fm_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 64'd50_000_000,
  parameter int              CNT_W       = 27,
  parameter longint unsigned TIMEOUT_CYC = 64'd50_000_000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sig_i,
  output logic [CNT_W-1:0] freq_o,
  output logic             valid_o,
  output logic             ovf_o,
  output logic             busy_o
);

  localparam longint unsigned CNT_MAX  = (64'd1 << CNT_W) - 64'd1;
  localparam longint unsigned LIM_L    = (TIMEOUT_CYC < CNT_MAX) ? TIMEOUT_CYC : CNT_MAX;
  localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(LIM_L);
  localparam logic [CNT_W-1:0] DIVIDEND = CNT_W'(CLK_HZ);

  // Named internal events, also watched by the bound checker.
  logic             fall_w;
  logic             start_w;
  logic             busy_w;
  logic             done_w;
  logic [CNT_W-1:0] period_w;
  logic [CNT_W-1:0] quo_w;
  logic [CNT_W-1:0] cnt_w;
  state_e           state_w;

  fm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sig_i  (sig_i),
    .fall_o (fall_w)
  );

  fm_ctrl #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_ctrl (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .fall_i     (fall_w),
    .div_busy_i (busy_w),
    .div_done_i (done_w),
    .quo_i      (quo_w),
    .start_o    (start_w),
    .period_o   (period_w),
    .freq_o     (freq_o),
    .valid_o    (valid_o),
    .ovf_o      (ovf_o),
    .state_o    (state_w),
    .cnt_o      (cnt_w)
  );

  fm_divider #(.W(CNT_W)) u_div (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_w),
    .num_i   (DIVIDEND),
    .den_i   (period_w),
    .busy_o  (busy_w),
    .done_o  (done_w),
    .quo_o   (quo_w)
  );

  assign busy_o = busy_w;

endmodule

// File: rtl/fm_checker.sv
`timescale 1ns/1ps
module fm_checker
  import fm_pkg::*;
#(
  parameter int               CNT_W  = 27,
  parameter int               STAGES = 2,
  parameter logic [CNT_W-1:0] LIMIT  = '1
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             sig_i,
  input logic             fall_i,
  input state_e           state_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             start_i,
  input logic             busy_i,
  input logic             done_i,
  input logic             valid_i,
  input logic             ovf_i
);

  // R1: a detected fall matches a 1-then-0 history on the pin.
  p_fall_synced_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    fall_i |-> ($past(sig_i, STAGES) && !$past(sig_i, STAGES - 1)));

  // R3: the result strobe lasts one cycle.
  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |=> !valid_i);

  // R4: the counter never passes the limit.
  p_count_bound_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_i == ST_COUNT) |-> (cnt_i <= LIMIT));

  // R4: an overflow only comes out of counting.
  p_ovf_from_count_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    ovf_i |-> ($past(state_i) == ST_COUNT));

  // R5: a result follows a divider completion.
  p_valid_after_div_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |-> $past(done_i));

  // R5: no measurement starts while the divider runs.
  p_no_start_busy_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(state_i) == ST_IDLE && state_i == ST_COUNT) |-> !$past(busy_i));

  // R5: a division is launched only into an idle divider.
  p_launch_idle_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    start_i |-> !busy_i);

  // R6: an illegal code falls back to idle.
  p_illegal_recover_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !(state_i inside {ST_IDLE, ST_COUNT, ST_DIVIDE, ST_DONE}) |=> (state_i == ST_IDLE));

  // R7: reset leaves the block idle and quiet.
  p_reset_idle_r7: assert property (@(posedge clk_i)
    rst_i |=> (state_i == ST_IDLE && !valid_i && !ovf_i && !busy_i));

  // R9: result and overflow are exclusive.
  p_excl_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !(valid_i && ovf_i));

endmodule

bind freq_meter fm_checker #(
  .CNT_W  (CNT_W),
  .STAGES (SYNC_STAGES),
  .LIMIT  (LIMIT)
) u_fm_checker (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .sig_i   (sig_i),
  .fall_i  (fall_w),
  .state_i (state_w),
  .cnt_i   (cnt_w),
  .start_i (start_w),
  .busy_i  (busy_w),
  .done_i  (done_w),
  .valid_i (valid_o),
  .ovf_i   (ovf_o)
);

// File: tb/freq_meter_bench.sv
`timescale 1ns/1ps
module freq_meter_bench;

  // Scaled-down clock rate so long periods fit the run.
  localparam longint unsigned CLK_HZ = 64'd5_000_000;
  localparam int              CNT_W  = 27;
  localparam longint unsigned TMO    = 64'd6000;
  localparam real             TCK    = 4.0;

  // Stimulus table: high cycles, low cycles, expected Hz.
  localparam int NV = 6;
  localparam int V_HI [NV] = '{50, 2500, 2, 30, 7, 3000};
  localparam int V_LO [NV] = '{50, 2500, 3, 70, 6, 3000};
  localparam int V_EXP[NV] = '{50000, 1000, 1000000, 50000, 384615, 833};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             gen_sig = 1'b0;
  logic             man_sig = 1'b0;
  bit               gen_on = 1'b0;
  int               gen_hi = 50;
  int               gen_lo = 50;
  logic             sig;
  logic [CNT_W-1:0] freq;
  logic             valid, ovf, busy;
  int               n_tests = 0;
  int               n_fail  = 0;
  int               n_both  = 0;

  assign sig = gen_on ? gen_sig : man_sig;

  freq_meter #(
    .CLK_HZ      (CLK_HZ),
    .CNT_W       (CNT_W),
    .TIMEOUT_CYC (TMO),
    .SYNC_STAGES (2)
  ) u_freq_meter (
    .clk_i   (clk),
    .rst_i   (rst),
    .sig_i   (sig),
    .freq_o  (freq),
    .valid_o (valid),
    .ovf_o   (ovf),
    .busy_o  (busy)
  );

  always #2 clk = ~clk;

  // Square-wave generator; its phase is set when it is switched on.
  initial begin
    forever begin
      if (!gen_on) begin
        gen_sig = 1'b0;
        wait (gen_on);
      end else begin
        gen_sig = 1'b1;
        #(gen_hi * TCK);
        gen_sig = 1'b0;
        #(gen_lo * TCK);
      end
    end
  end

  always @(negedge clk) if (valid && ovf) n_both++;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(180000 * TCK);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic restart(input int hi, input int lo);
    int wait_n = gen_hi + gen_lo + 4;
    gen_on = 1'b0;
    repeat (wait_n) @(negedge clk);
    gen_hi = hi;
    gen_lo = lo;
    @(negedge clk);
    #(real'($urandom_range(100, 1900)) / 1000.0);
    gen_on = 1'b1;
  endtask

  // kind: 0 none, 1 result, 2 overflow
  task automatic wait_event(input int limit, input bit skip_ovf,
                            output int kind, output longint f);
    bit stop = 1'b0;
    kind = 0;
    f = 0;
    for (int i = 0; i < limit && !stop; i++) begin
      @(negedge clk);
      if (valid) begin
        kind = 1; f = longint'(freq); stop = 1'b1;
      end else if (ovf && !skip_ovf) begin
        kind = 2; stop = 1'b1;
      end
    end
  endtask

  task automatic measure(input int hi, input int lo, input int exp);
    int     kind;
    longint f;
    int     lim = 4 * (hi + lo) + 300;
    restart(hi, lo);
    wait_event(lim, 1'b1, kind, f);  // first result may span the switch
    wait_event(lim, 1'b0, kind, f);
    check(kind == 1, "R2", "result strobe", kind, 1);
    check(f >= exp - 1 && f <= exp + 1, "R1 R2 R8", "frequency", f, exp);
    @(negedge clk);
    check(!valid, "R3", "strobe width", valid, 0);
    repeat (2) @(negedge clk);
    check(longint'(freq) == f, "R3", "held value", freq, f);
  endtask

  initial begin
    int     kind;
    longint f;
    int     cnt_v;
    int     cnt_o;
    int     blen;

    repeat (4) @(negedge clk);
    // R7: reset state at the ports.
    check(freq == '0 && !valid && !ovf && !busy, "R7", "reset outputs",
          {valid, ovf, busy}, 0);
    rst = 1'b0;

    // Table walk: R2/R8 at 50 kHz, 1 kHz, 1 MHz and others; R4 boundary last.
    for (int v = 0; v < NV; v++) begin
      measure(V_HI[v], V_LO[v], V_EXP[v]);
    end

    // R5: divider busy width and result timing.
    restart(50, 50);
    wait_event(500, 1'b1, kind, f);
    blen = 0;
    while (!busy && blen < 500) begin @(negedge clk); blen++; end
    blen = 0;
    while (busy && blen < 100) begin @(negedge clk); blen++; end
    check(blen == CNT_W, "R5", "busy cycles", blen, CNT_W);
    check(valid == 1'b0, "R5", "no strobe as busy falls", valid, 0);
    @(negedge clk);
    check(valid == 1'b1, "R5", "strobe after busy", valid, 1);
    check(longint'(freq) == 50000, "R5", "division result", freq, 50000);

    // R6: illegal state code recovers to idle and measuring resumes.
    @(negedge clk);
    force u_freq_meter.u_ctrl.state_q = fm_pkg::state_e'(3'd6);
    #1;
    release u_freq_meter.u_ctrl.state_q;
    cnt_v = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (valid || ovf) cnt_v++;
    end
    check(cnt_v == 0, "R6", "quiet after illegal code", cnt_v, 0);
    wait_event(600, 1'b0, kind, f);
    check(kind == 1 && f == 50000, "R6", "measure after recovery", f, 50000);

    // R4: period one clock past the limit overflows and never yields a result.
    restart(3000, 3001);
    wait_event(30000, 1'b0, kind, f);
    while (kind == 1) wait_event(30000, 1'b0, kind, f);
    check(kind == 2, "R4", "overflow strobe", kind, 2);
    @(negedge clk);
    check(!ovf, "R4", "overflow width", ovf, 0);
    cnt_v = 0;
    cnt_o = 0;
    for (int i = 0; i < 13000; i++) begin
      @(negedge clk);
      if (valid) cnt_v++;
      if (ovf) cnt_o++;
    end
    check(cnt_v == 0, "R4", "no result past limit", cnt_v, 0);
    check(cnt_o >= 1, "R4", "repeated overflow", cnt_o, 1);

    // R7: a fall during reset starts nothing.
    gen_on = 1'b0;
    man_sig = 1'b1;
    repeat (6010) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 man_sig = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(freq == '0 && !busy, "R7", "outputs cleared by reset", freq, 0);
    cnt_v = 0;
    cnt_o = 0;
    for (int i = 0; i < 6100; i++) begin
      @(negedge clk);
      if (valid) cnt_v++;
      if (ovf) cnt_o++;
    end
    check(cnt_v == 0 && cnt_o == 0, "R7", "edge in reset ignored", cnt_v + cnt_o, 0);

    // R9: no cycle with both strobes over the whole run.
    check(n_both == 0, "R9", "both strobes together", n_both, 0);

    summary();
    $finish;
  end

endmodule